// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block turns four external interrupt pins into sticky request flags. One pin, the filtered pin, first passes through a sampled noise filter. The filter takes a new level only after two consecutive samples agree on it. Its samples are taken either on every system clock cycle or once every `DIV_RATIO` cycles (64 by default), as bit 3 of that pin's mode nibble selects. The filtered level feeds an edge detector and is also offered as the pin's port read value.

A second pin has a programmable detection edge. The third pin reacts only to rising edges, and the fourth reacts to both edges. Two 4-bit mode registers are loaded as whole nibbles through a simple write port. Each detected edge sets a per-source request flag, which holds until software clears it. The interrupt output of each source is its flag masked by the matching enable bit.

Top module: `ext_irq_edge`

## Requirements
- R1: After reset, all flags, all interrupt outputs and the filtered level are 0, and both mode registers are 0, which selects rising-edge detection and per-cycle sampling.
- R2: In per-cycle sampling, a filtered-pin pulse lasting one clock cycle is rejected: neither the filtered level nor flag bit 0 changes. A level held for two or more cycles is accepted.
- R3: With mode register 0 bit 3 set, samples are taken once every DIV_RATIO cycles. A pulse shorter than DIV_RATIO cycles is always rejected, and a pulse longer than 2*DIV_RATIO cycles is always accepted.
- R4: `port_flt` shows the filtered level. In per-cycle sampling, a stable new pin level appears on it two clock edges after it is first applied, and the after-edge value always equals the pin value sampled at that edge.
- R5: Mode bits [1:0] pick the edge: 00 rising, 01 falling, 10 both, 11 none. The write address 0 loads the filtered pin's nibble and address 1 loads the selectable pin's nibble.
- R6: `pin_rise` sets flag bit 2 on a rising edge only, at the clock edge where the new high level is first sampled.
- R7: `pin_both` sets flag bit 3 on every change of level, at the clock edge where the new level is first sampled.
- R8: Flag bits are ordered filtered pin 0, selectable pin 1, rising pin 2, both-edge pin 3. A set flag holds until a 1 on the matching `flag_clr` bit clears it at the next clock edge.
- R9: When a clear and a new edge event for the same source fall in the same cycle, the flag ends up set.
- R10: Each `irq_out` bit equals its flag bit ANDed with the matching `irq_en` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_flt | input | 1 | Filtered interrupt pin (synchronous) |
| pin_sel | input | 1 | Interrupt pin with selectable edge |
| pin_rise | input | 1 | Rising-edge-only interrupt pin |
| pin_both | input | 1 | Both-edge interrupt pin |
| mode_we | input | 1 | Mode register write strobe |
| mode_addr | input | 1 | Mode register select (0 filtered pin, 1 selectable pin) |
| mode_wdata | input | 4 | Mode nibble to write |
| irq_en | input | 4 | Per-source enable bits |
| flag_clr | input | 4 | Write-one-to-clear mask for the flags |
| irq_flag | output | 4 | Sticky request flags |
| irq_out | output | 4 | Enabled interrupt requests |
| port_flt | output | 1 | Filtered level of pin_flt for port reads |

## Verification
A software clear and a fresh edge on the same source can land in the same clock cycle, and the set must win. The bench provokes this on purpose: it raises the rising-only pin while pulsing that source's clear bit against a flag that is already set, and it expects the flag to stay at 1. It also does the reverse, a clear with no event, and expects 0. The random phase lets clears and edges on all three unfiltered pins collide freely, and a bench model settles each collision with set priority.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int NSRC     = 4;
    localparam int MODE_W   = 4;
    localparam int SRC_FLT  = 0;
    localparam int SRC_SEL  = 1;
    localparam int SRC_RISE = 2;
    localparam int SRC_BOTH = 3;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_NONE = 2'b11
    } edge_sel_e;

    // nibble layout: [3] slow sampling, [2] unused, [1:0] edge choice
    typedef struct packed {
        logic      slow_smp;
        logic      spare;
        edge_sel_e edge_sel;
    } mode_t;

    function automatic logic edge_hit(edge_sel_e sel, logic cur, logic prev);
        logic hit;
        case (sel)
            EDGE_RISE: hit = cur & ~prev;
            EDGE_FALL: hit = ~cur & prev;
            EDGE_BOTH: hit = cur ^ prev;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/irq_sample_filter.sv
module irq_sample_filter #(
    parameter int DIV_RATIO = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic slow_sel,
    input  logic pin_i,
    output logic level_o
);
    localparam int CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DIV_RATIO - 1);

    logic [CW-1:0] div_cnt;
    logic          strobe;
    logic          last_smp;
    logic          level_q;

    always_ff @(posedge clk) begin
        if (rst || div_cnt == CNT_LAST) div_cnt <= '0;
        else                            div_cnt <= div_cnt + 1'b1;
    end

    assign strobe = slow_sel ? (div_cnt == CNT_LAST) : 1'b1;

    // a level is taken only when two consecutive samples agree
    always_ff @(posedge clk) begin
        if (rst) begin
            last_smp <= 1'b0;
            level_q  <= 1'b0;
        end else if (strobe) begin
            last_smp <= pin_i;
            if (pin_i == last_smp) level_q <= pin_i;
        end
    end

    assign level_o = level_q;
endmodule

// File: rtl/irq_edge_sel.sv
module irq_edge_sel
    import ext_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sig_i,
    input  edge_sel_e sel_i,
    output logic      hit_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sig_i;
    end

    assign hit_o = edge_hit(sel_i, sig_i, prev_q);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q;

    // a new event outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (flag_q & ~clr_i) | set_i;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/ext_irq_edge.sv
module ext_irq_edge
    import ext_irq_pkg::*;
#(
    parameter int DIV_RATIO = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_flt,
    input  logic              pin_sel,
    input  logic              pin_rise,
    input  logic              pin_both,
    input  logic              mode_we,
    input  logic              mode_addr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic [NSRC-1:0]   irq_en,
    input  logic [NSRC-1:0]   flag_clr,
    output logic [NSRC-1:0]   irq_flag,
    output logic [NSRC-1:0]   irq_out,
    output logic              port_flt
);
    mode_t     mode_q [2];
    logic      flt_level;
    logic      src_sig  [NSRC];
    edge_sel_e src_mode [NSRC];
    logic [NSRC-1:0] src_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q[0] <= '0;
            mode_q[1] <= '0;
        end else if (mode_we) begin
            mode_q[mode_addr] <= mode_t'(mode_wdata);
        end
    end

    irq_sample_filter #(.DIV_RATIO(DIV_RATIO)) u_filter (
        .clk      (clk),
        .rst      (rst),
        .slow_sel (mode_q[0].slow_smp),
        .pin_i    (pin_flt),
        .level_o  (flt_level)
    );

    always_comb begin
        src_sig[SRC_FLT]   = flt_level;
        src_sig[SRC_SEL]   = pin_sel;
        src_sig[SRC_RISE]  = pin_rise;
        src_sig[SRC_BOTH]  = pin_both;
        src_mode[SRC_FLT]  = mode_q[0].edge_sel;
        src_mode[SRC_SEL]  = mode_q[1].edge_sel;
        src_mode[SRC_RISE] = EDGE_RISE;
        src_mode[SRC_BOTH] = EDGE_BOTH;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_det
        irq_edge_sel u_det (
            .clk   (clk),
            .rst   (rst),
            .sig_i (src_sig[i]),
            .sel_i (src_mode[i]),
            .hit_o (src_hit[i])
        );
    end

    irq_flag_bank #(.N(NSRC)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (src_hit),
        .clr_i  (flag_clr),
        .flag_o (irq_flag)
    );

    assign irq_out  = irq_flag & irq_en;
    assign port_flt = flt_level;
endmodule

// File: rtl/ext_irq_edge_chk.sv
module ext_irq_edge_chk (
    input logic       clk,
    input logic       rst,
    input logic       pin_flt,
    input logic       pin_rise,
    input logic [3:0] flag_clr,
    input logic [3:0] irq_flag,
    input logic       port_flt,
    input logic [1:0] sel_mode
);
    // R1: reset leaves every flag and the filtered level low
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (irq_flag == 4'b0 && port_flt == 1'b0));

    // R4: a new filtered level is always the pin value sampled at that edge
    a_r4_level_from_pin: assert property (@(posedge clk) disable iff (rst)
        (port_flt != $past(port_flt)) |-> (port_flt == $past(pin_flt)));

    // R8: a set flag survives any edge without its clear bit
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(irq_flag) & ~$past(flag_clr)) & ~irq_flag) == 4'b0));

    // R6: the rising-only flag rises only while that pin is high
    a_r6_rise_needs_high: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag[2]) |-> $past(pin_rise));

    // R5: the selectable source never rises while its edge choice is none
    a_r5_none_blocks: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag[1]) |-> ($past(sel_mode) != 2'b11));
endmodule

bind ext_irq_edge ext_irq_edge_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pin_flt  (pin_flt),
    .pin_rise (pin_rise),
    .flag_clr (flag_clr),
    .irq_flag (irq_flag),
    .port_flt (port_flt),
    .sel_mode (mode_q[1].edge_sel)
);

// File: tb/ext_irq_edge_tb.sv
`timescale 1ns/1ps
module ext_irq_edge_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       pin_flt, pin_sel, pin_rise, pin_both;
    logic       mode_we, mode_addr;
    logic [3:0] mode_wdata, irq_en, flag_clr;
    logic [3:0] irq_flag, irq_out;
    logic       port_flt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ext_irq_edge #(.DIV_RATIO(64)) u_dut (
        .clk(clk), .rst(rst), .pin_flt(pin_flt), .pin_sel(pin_sel),
        .pin_rise(pin_rise), .pin_both(pin_both), .mode_we(mode_we),
        .mode_addr(mode_addr), .mode_wdata(mode_wdata), .irq_en(irq_en),
        .flag_clr(flag_clr), .irq_flag(irq_flag), .irq_out(irq_out),
        .port_flt(port_flt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic write_mode(input logic addr, input logic [3:0] val);
        mode_we = 1'b1; mode_addr = addr; mode_wdata = val;
        tick();
        mode_we = 1'b0;
    endtask

    task automatic clear_all();
        flag_clr = 4'hF;
        tick();
        flag_clr = 4'h0;
    endtask

    function automatic logic sel_event(logic [1:0] m, logic cur, logic prev);
        case (m)
            2'b00:   return cur & ~prev;
            2'b01:   return ~cur & prev;
            2'b10:   return cur ^ prev;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] m_flag;
        logic [1:0] m_mode;
        logic p_sel, p_rise, p_both;
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; pin_flt = 0; pin_sel = 0; pin_rise = 0; pin_both = 0;
        mode_we = 0; mode_addr = 0; mode_wdata = 0; irq_en = 4'hF; flag_clr = 0;
        tick(3);
        rst = 1'b0;
        tick();
        check("R1 flags after reset", irq_flag, 4'h0);
        check("R1 irq_out after reset", irq_out, 4'h0);
        check("R1 port_flt after reset", port_flt, 1'b0);

        // R1: default mode is rising on the selectable pin
        pin_sel = 1; tick();
        check("R1 default rising on sel pin", irq_flag[1], 1'b1);
        pin_sel = 0; clear_all(); tick();
        check("R1 no flag on falling by default", irq_flag[1], 1'b0);

        // R2: single-cycle pulse rejected
        pin_flt = 1; tick(); pin_flt = 0; tick(5);
        check("R2 1-cycle pulse level", port_flt, 1'b0);
        check("R2 1-cycle pulse flag", irq_flag[0], 1'b0);

        // R4/R2: stable high appears after two edges, flag one edge later
        pin_flt = 1; tick();
        check("R4 level after one edge", port_flt, 1'b0);
        tick();
        check("R4 level after two edges", port_flt, 1'b1);
        check("R2 flag not yet", irq_flag[0], 1'b0);
        tick();
        check("R2 rising accepted", irq_flag[0], 1'b1);

        // R5 falling on filtered pin
        write_mode(1'b0, 4'b0001); clear_all();
        pin_flt = 0; tick(4);
        check("R5 falling flag", irq_flag[0], 1'b1);
        clear_all(); pin_flt = 1; tick(4);
        check("R5 falling ignores rising", irq_flag[0], 1'b0);
        // R5 none
        write_mode(1'b0, 4'b0011);
        pin_flt = 0; tick(4);
        check("R5 none falling", irq_flag[0], 1'b0);
        pin_flt = 1; tick(4);
        check("R5 none rising", irq_flag[0], 1'b0);
        // R5 both
        write_mode(1'b0, 4'b0010);
        pin_flt = 0; tick(4);
        check("R5 both falling", irq_flag[0], 1'b1);
        clear_all(); pin_flt = 1; tick(4);
        check("R5 both rising", irq_flag[0], 1'b1);
        pin_flt = 0; tick(4); clear_all();

        // R3: slow sampling, rising
        write_mode(1'b0, 4'b1000); tick(130);
        for (int r = 0; r < 3; r++) begin
            pin_flt = 1; tick(40 + r * 7); pin_flt = 0; tick(150);
            check("R3 short pulse level", port_flt, 1'b0);
            check("R3 short pulse flag", irq_flag[0], 1'b0);
        end
        pin_flt = 1; tick(131);
        check("R3 long pulse flag", irq_flag[0], 1'b1);
        check("R4 slow level high", port_flt, 1'b1);
        pin_flt = 0; tick(140); clear_all();
        write_mode(1'b0, 4'b0000);

        // R9: set wins over clear, then plain clear
        pin_rise = 1; tick();
        check("R6 rising sets flag 2", irq_flag[2], 1'b1);
        pin_rise = 0; tick(2);
        check("R6 falling leaves flag", irq_flag[2], 1'b1);
        check("R8 flag sticky", irq_flag[2], 1'b1);
        pin_rise = 1; flag_clr = 4'b0100; tick(); flag_clr = 0;
        check("R9 set beats clear", irq_flag[2], 1'b1);
        flag_clr = 4'b0100; tick(); flag_clr = 0;
        check("R8 clear without event", irq_flag[2], 1'b0);
        pin_rise = 0; tick();

        // R10 masking
        pin_both = 1; tick();
        check("R7 both-edge rise", irq_flag[3], 1'b1);
        irq_en = 4'b0111; #1;
        check("R10 masked out", irq_out, 4'b0000);
        irq_en = 4'b1000; #1;
        check("R10 enabled out", irq_out, 4'b1000);
        clear_all(); pin_both = 0; tick();
        check("R7 both-edge fall", irq_flag[3], 1'b1);
        clear_all();

        // random phase on unfiltered pins with a model
        m_flag = irq_flag; m_mode = 2'b00;
        p_sel = pin_sel; p_rise = pin_rise; p_both = pin_both;
        for (int c = 0; c < 400; c++) begin
            logic [3:0] ev, clr;
            logic       we;
            logic [1:0] nm;
            pin_sel  = $urandom_range(0, 1);
            pin_rise = $urandom_range(0, 1);
            pin_both = $urandom_range(0, 1);
            clr      = 4'($urandom_range(0, 15)) & {4{($urandom_range(0, 3) == 0)}};
            flag_clr = clr;
            irq_en   = 4'($urandom_range(0, 15));
            we       = ($urandom_range(0, 15) == 0);
            nm       = 2'($urandom_range(0, 3));
            mode_we = we; mode_addr = 1'b1; mode_wdata = {2'b00, nm};
            ev = {p_both ^ pin_both, pin_rise & ~p_rise,
                  sel_event(m_mode, pin_sel, p_sel), 1'b0};
            tick();
            m_flag = (m_flag & ~clr) | ev;
            if (we) m_mode = nm;
            p_sel = pin_sel; p_rise = pin_rise; p_both = pin_both;
            check("R8 R9 R5 R6 R7 random flags", irq_flag, m_flag);
            check("R10 random irq_out", irq_out, m_flag & irq_en);
        end
        mode_we = 0; flag_clr = 0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule